// File: doc/BRIEF.md
# Reloading Down-Count Timer Channel

This block is one 32-bit timer channel. A counter steps down by one on each tick of a prescaler, and the tick rate is one of five power-of-four fractions of the peripheral clock. When a tick finds the counter at zero, the counter takes the value of a reload register, and a sticky underflow flag is set. The interrupt output is that flag gated by an enable bit.

Software reaches the channel through a word-addressed port with a select, a write strobe, a two-bit address, write data and combinational read data. Three words are mapped: the reload value, the live counter and a control word. A `run` input comes from a start bit held elsewhere. While `run` is high the channel counts, and while it is low the channel holds. A control write that carries a reserved encoding changes nothing. Such a write, or any write to the unmapped fourth word, pulses an error output for one cycle.

Top module: `reload_timer`

## Requirements
- R1: After reset, the reload word and the counter both read 0xFFFFFFFF, the control word reads 0, and `irq` and `err_pulse` are low.
- R2: The word addresses are fixed: 0 is the reload value, 1 is the counter and 2 is the control word. A write to address 3 changes no state, and reading address 3 returns 0.
- R3: Control bits [2:0] select the tick period. Code k (k = 0..4) gives one tick every 4^(k+1) clock cycles while `run` is high. The first decrement comes on the 4^(k+1)-th rising edge after `run` goes high.
- R4: When a tick finds the counter at 0, the counter loads the reload value on that same edge and the underflow flag is set on that edge.
- R5: While `run` is low, the counter holds its value. A write to address 1 loads the counter on the write edge, whatever the state of `run`.
- R6: An accepted control write with bit 8 at 0 clears the underflow flag. An accepted control write with bit 8 at 1 leaves the flag as it was, so it never sets the flag.
- R7: A read of address 2 returns the stored rate code in bits [2:0] and the interrupt enable in bit 5, with the live underflow flag in bit 8. All other bits read as 0.
- R8: `irq` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R9: A control write is rejected in any of these cases: the rate code is 5 to 7, bits [4:3], [7:6] or 9 are nonzero, or any bit from 10 upward is set. A rejected write changes nothing, including the flag. `err_pulse` goes high for exactly the one cycle after a rejected write or a write to address 3.
- R10: An accepted control write that changes the rate code restarts the prescaler phase. No tick happens on the write edge, and the next tick comes a full new period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable from the external start bit |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Underflow interrupt |
| err_pulse | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bound checker watches several behaviours on every cycle:
- the counter holds while the channel is stopped and no load is written;
- a zero-count tick leaves the old reload value in the counter;
- the flag and the interrupt rise only after an underflow or an accepted control write;
- the error pulse follows a write, and a rejected write leaves the control state unchanged.

Only the directed scenarios can show the exact tick spacing for each rate code, the phase restart after a rate change, the read-back format and the reset values. These need cycle counting against expected numbers that no single-cycle property carries.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned RATE_W      = 3;
    localparam int unsigned IE_BIT      = 5;
    localparam int unsigned FLAG_BIT    = 8;
    localparam int unsigned FIRST_RSV   = 10;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              ie;
    } ctrl_t;

    // True when a control word carries any reserved encoding.
    function automatic logic ctrl_word_bad(input logic [WORD_W-1:0] w,
                                           input int unsigned n_codes);
        logic bad;
        bad = (int'(w[RATE_W-1:0]) >= int'(n_codes));
        bad = bad | (w[4:3] != 2'b00);
        bad = bad | (w[7:6] != 2'b00);
        bad = bad | w[9];
        bad = bad | (w[WORD_W-1:FIRST_RSV] != '0);
        return bad;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word_read(input ctrl_t c,
                                                         input logic flag);
        logic [WORD_W-1:0] r;
        r = '0;
        r[RATE_W-1:0] = c.rate;
        r[IE_BIT]     = c.ie;
        r[FLAG_BIT]   = flag;
        return r;
    endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int unsigned STEP_LOG2 = 2,
    parameter int unsigned N_CODES   = 5,
    parameter int unsigned RATE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int unsigned PH_W = STEP_LOG2 * N_CODES;

    logic [PH_W-1:0] lim_tab [N_CODES];
    logic [PH_W-1:0] limit;
    logic [PH_W-1:0] phase_q;

    for (genvar g = 0; g < N_CODES; g++) begin : g_lim
        assign lim_tab[g] = PH_W'((64'd1 << ((g + 1) * STEP_LOG2)) - 64'd1);
    end

    always_comb begin
        limit = lim_tab[0];
        for (int i = 0; i < N_CODES; i++) begin
            if (int'(rate) == i) limit = lim_tab[i];
        end
    end

    assign tick = run && !restart && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase_q <= '0;
        end else if (phase_q == limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    assign underflow = tick && !load_en && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (load_en) begin
            count <= load_val;
        end else if (underflow) begin
            count <= reload_val;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/timer_ctrl_reg.sv
module timer_ctrl_reg
    import rtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic              wr_ie,
    input  logic              wr_flag,
    input  logic              underflow,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic              rate_change
);
    assign rate_change = wr_ok && (wr_rate != ctrl.rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ok) begin
            ctrl.rate <= wr_rate;
            ctrl.ie   <= wr_ie;
        end
    end

    // Set beats clear when both land on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (underflow) begin
            flag <= 1'b1;
        end else if (wr_ok && !wr_flag) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtimer_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned N_CODES   = 5,
    parameter int unsigned STEP_LOG2 = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        err_pulse
);
    reg_sel_e         sel;
    logic             wr_any;
    logic             wr_reload;
    logic             wr_count;
    logic             wr_ctrl;
    logic             ctrl_bad;
    logic             wr_ctrl_ok;
    logic             wr_reject;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             underflow;
    logic             flag;
    logic             rate_change;
    ctrl_t            ctrl;

    assign sel        = reg_sel_e'(bus_addr);
    assign wr_any     = bus_sel && bus_we;
    assign wr_reload  = wr_any && (sel == SEL_RELOAD);
    assign wr_count   = wr_any && (sel == SEL_COUNT);
    assign wr_ctrl    = wr_any && (sel == SEL_CTRL);
    assign ctrl_bad   = ctrl_word_bad(bus_wdata, N_CODES);
    assign wr_ctrl_ok = wr_ctrl && !ctrl_bad;
    assign wr_reject  = (wr_ctrl && ctrl_bad) || (wr_any && (sel == SEL_NONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q  <= '1;
            err_pulse <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
            err_pulse <= wr_reject;
        end
    end

    timer_prescaler #(
        .STEP_LOG2 (STEP_LOG2),
        .N_CODES   (N_CODES),
        .RATE_W    (RATE_W)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (rate_change),
        .rate    (ctrl.rate),
        .tick    (tick)
    );

    timer_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_en    (wr_count),
        .load_val   (bus_wdata[CNT_W-1:0]),
        .reload_val (reload_q),
        .tick       (tick),
        .count      (count),
        .underflow  (underflow)
    );

    timer_ctrl_reg u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wr_ok       (wr_ctrl_ok),
        .wr_rate     (bus_wdata[RATE_W-1:0]),
        .wr_ie       (bus_wdata[IE_BIT]),
        .wr_flag     (bus_wdata[FLAG_BIT]),
        .underflow   (underflow),
        .ctrl        (ctrl),
        .flag        (flag),
        .rate_change (rate_change)
    );

    assign irq = flag && ctrl.ie;

    always_comb begin
        unique case (sel)
            SEL_RELOAD: bus_rdata = 32'(reload_q);
            SEL_COUNT:  bus_rdata = 32'(count);
            SEL_CTRL:   bus_rdata = ctrl_word_read(ctrl, flag);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             wr_any,
    input logic             wr_count,
    input logic             wr_ctrl_ok,
    input logic             tick,
    input logic             underflow,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_q,
    input logic             flag,
    input logic [3:0]       ctrl_bits,
    input logic             irq,
    input logic             err_pulse
);
    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_count) |=> (count == $past(count)));

    // R4
    reload_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_count && count == '0) |=> (count == $past(reload_q)));

    // R4
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(underflow));

    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(underflow) || $past(wr_ctrl_ok)));

    // R9
    err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(wr_any));

    // R9
    reject_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (ctrl_bits == $past(ctrl_bits)));
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .wr_any     (wr_any),
    .wr_count   (wr_count),
    .wr_ctrl_ok (wr_ctrl_ok),
    .tick       (tick),
    .underflow  (underflow),
    .count      (count),
    .reload_q   (reload_q),
    .flag       (flag),
    .ctrl_bits  (ctrl),
    .irq        (irq),
    .err_pulse  (err_pulse)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        err_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    reload_timer dut (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .err_pulse (err_pulse)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); check("R1 reload", d, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R1 count", d, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R1 ctrl", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 err", {31'b0, err_pulse}, 32'h0);
    endtask

    task automatic t_map_hold;
        logic [31:0] d;
        wr(2'd0, 32'h1234_5678); rd(2'd0, d); check("R2 reload rw", d, 32'h1234_5678);
        wr(2'd1, 32'd5); rd(2'd1, d); check("R5 count load", d, 32'd5);
        wr(2'd3, 32'hFFFF_FFFF);
        check("R9 err addr3", {31'b0, err_pulse}, 32'h1);
        rd(2'd3, d); check("R2 addr3 reads 0", d, 32'h0);
        rd(2'd0, d); check("R2 addr3 no effect", d, 32'h1234_5678);
        cycles(50);
        rd(2'd1, d); check("R5 hold stopped", d, 32'd5);
    endtask

    task automatic t_underflow;
        logic [31:0] d;
        wr(2'd0, 32'd7); wr(2'd1, 32'd3); wr(2'd2, 32'h20);
        run = 1'b1;
        cycles(3); rd(2'd1, d); check("R3 code0 before tick", d, 32'd3);
        cycles(1); rd(2'd1, d); check("R3 code0 first tick", d, 32'd2);
        cycles(8); rd(2'd1, d); check("R3 reach zero", d, 32'd0);
        check("R8 irq low before", {31'b0, irq}, 32'h0);
        cycles(4); run = 1'b0;
        rd(2'd1, d); check("R4 reload", d, 32'd7);
        rd(2'd2, d); check("R7 ctrl with flag", d, 32'h120);
        check("R8 irq high", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_flag_clear;
        logic [31:0] d;
        wr(2'd2, 32'h120); rd(2'd2, d); check("R6 write one keeps", d, 32'h120);
        wr(2'd2, 32'h025);
        check("R9 reserved rate err", {31'b0, err_pulse}, 32'h1);
        cycles(1); check("R9 err one cycle", {31'b0, err_pulse}, 32'h0);
        rd(2'd2, d); check("R9 reject keeps flag", d, 32'h120);
        wr(2'd2, 32'h020); rd(2'd2, d); check("R6 write zero clears", d, 32'h020);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h100); rd(2'd2, d); check("R6 write one never sets", d, 32'h0);
    endtask

    task automatic t_ie_off;
        logic [31:0] d;
        wr(2'd0, 32'd9); wr(2'd1, 32'd0); wr(2'd2, 32'h0);
        run = 1'b1; cycles(4); run = 1'b0;
        rd(2'd1, d); check("R4 zero reload", d, 32'd9);
        rd(2'd2, d); check("R7 flag without ie", d, 32'h100);
        check("R8 irq gated", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h120);
        check("R8 irq on enable", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_rate(input logic [2:0] code, input int period);
        logic [31:0] d;
        wr(2'd2, {29'b0, code}); wr(2'd1, 32'd10);
        run = 1'b1;
        cycles(period - 1); rd(2'd1, d); check("R3 before tick", d, 32'd10);
        cycles(1); rd(2'd1, d); check("R3 on tick", d, 32'd9);
        run = 1'b0; cycles(1);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(2'd2, 32'h21);
        wr(2'd2, 32'h0421); check("R9 bit10 err", {31'b0, err_pulse}, 32'h1);
        wr(2'd2, 32'h29);   check("R9 edge bits err", {31'b0, err_pulse}, 32'h1);
        wr(2'd2, 32'hE1);   check("R9 capture bits err", {31'b0, err_pulse}, 32'h1);
        wr(2'd2, 32'h221);  check("R9 bit9 err", {31'b0, err_pulse}, 32'h1);
        rd(2'd2, d); check("R9 ctrl unchanged", d, 32'h21);
        wr(2'd2, 32'h24);   check("R9 code4 accepted", {31'b0, err_pulse}, 32'h0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_phase;
        logic [31:0] d;
        wr(2'd1, 32'd20);
        run = 1'b1; cycles(2);
        wr(2'd2, 32'h1);
        rd(2'd1, d); check("R10 no tick on write", d, 32'd20);
        cycles(15); rd(2'd1, d); check("R10 full period wait", d, 32'd20);
        cycles(1); rd(2'd1, d); check("R10 tick after restart", d, 32'd19);
        run = 1'b0; wr(2'd2, 32'h0);
    endtask

    initial begin
        fork
            begin
                cycles(3); rst = 1'b0; cycles(1);
                t_reset();
                t_map_hold();
                t_underflow();
                t_flag_clear();
                t_ie_off();
                t_rate(3'd1, 16);
                t_rate(3'd2, 64);
                t_rate(3'd4, 1024);
                t_reserved();
                t_phase();
            end
            begin
                cycles(100000);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule